// File: doc/BRIEF.md
# Grid Thread Index Dispatcher

This block turns a one-dimensional launch request into a stream of warp descriptors. A `start` pulse latches the problem size `n` and the thread count per block. From these the block computes how many blocks the grid holds, by rounding `n / block_size` up. It then walks the grid with the warp number as the inner loop and the block number as the outer loop. Each step emits one warp: the block and warp numbers, the global index of every lane, and a mask that marks which lanes hold real work.

The global index of a lane is `block * block_size + warp * LANES + lane`. A lane is active only when two conditions hold: its thread number inside the block is below the block size, and its global index is below `n`. The first condition clears the unused tail of a partial last warp. The second clears the lanes past the end of the problem. A warp whose first index already reaches `n` is never emitted, so the walk ends right after the warp that holds index `n-1`.

Descriptors leave through a valid/ready handshake. A one-cycle `done` pulse follows the last accepted descriptor.

Top module: `grid_warp_dispatcher`

## Requirements
- R1: After reset, `desc_valid`, `done` and `busy` are all low.
- R2: In a descriptor, lane `l` carries the global index `desc_block*bdim + desc_warp*LANES + l` in bits `[l*(IDX_W+1) +: IDX_W+1]` of `desc_idx`. `desc_base` equals the index of lane 0.
- R3: Bit `l` of `desc_mask` is 1 exactly when both `desc_warp*LANES + l < bdim` and the lane's global index `< n` hold. Lane 0 of an emitted descriptor is always active.
- R4: Descriptors come in order of rising warp number inside a block, then rising block number. The warp number restarts at 0 for each new block.
- R5: The blocks visited are 0 to `ceil(n/bdim)-1`. A warp whose base index is `>= n` is not emitted. The total number of descriptors therefore equals the number of (block, warp) pairs whose base index is below `n`.
- R6: While `desc_valid` is high and `desc_ready` is low, every descriptor output holds its value into the next cycle.
- R7: `done` goes high for exactly one cycle, in the cycle after the final handshake. `busy` and `desc_valid` are low from that cycle on.
- R8: A start with `cfg_n == 0` or `cfg_bdim == 0` produces no descriptor and raises `done` in the cycle after the start.
- R9: `start` is ignored while `busy` is high. The running walk is not disturbed.
- R10: After an accepted start with nonzero configuration, `busy` is high from the next cycle until `done`. `desc_valid` is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and begin a walk (honoured when idle) |
| cfg_n | input | IDX_W | Problem size n |
| cfg_bdim | input | BD_W | Threads per block |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at end of walk |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_block | output | IDX_W | Block number |
| desc_warp | output | BD_W | Warp number within block |
| desc_base | output | IDX_W+1 | Global index of lane 0 |
| desc_mask | output | LANES | Active-lane mask |
| desc_idx | output | LANES*(IDX_W+1) | Global index per lane, lane 0 in the low bits |

## Verification
The bench builds the block with `LANES=4`, `IDX_W=8` and `BD_W=5`. This narrow configuration makes it cheap to sweep every problem size from 0 to 40 against every block size from 0 to 11. The sweep covers empty grids, block sizes below, equal to and above the warp width, and partial last warps in every shape. It also covers grids that end in the middle of a block. A few larger cases run at the width limits (`n=255`, `bdim=31`). A pseudo-random ready pattern stalls descriptors throughout, and stray start pulses arrive in the middle of walks.

// File: rtl/gid_pkg.sv
package gid_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_RUN  = 2'd2
    } gid_state_e;
endpackage

// File: rtl/gid_ceil_div.sv
// Restoring divider, one quotient bit per cycle. The caller feeds
// numer = n + d - 1 to obtain ceil(n / d).
module gid_ceil_div #(
    parameter int NW = 17,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] numer,
    input  logic [DW-1:0] denom,
    output logic          fin,
    output logic [NW-1:0] quot
);
    localparam int CW = $clog2(NW + 1);

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [NW-1:0] q;
        logic [CW-1:0] cnt;
        logic          act;
        logic          fin;
    } div_s;

    div_s s_q, s_d;
    logic [DW:0] trial;

    always_comb begin
        s_d   = s_q;
        s_d.fin = 1'b0;
        trial = {s_q.rem, s_q.q[NW-1]};
        if (go) begin
            s_d.rem = '0;
            s_d.q   = numer;
            s_d.cnt = '0;
            s_d.act = 1'b1;
        end else if (s_q.act) begin
            if (trial >= {1'b0, denom}) begin
                s_d.rem = DW'(trial - {1'b0, denom});
                s_d.q   = {s_q.q[NW-2:0], 1'b1};
            end else begin
                s_d.rem = trial[DW-1:0];
                s_d.q   = {s_q.q[NW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt + CW'(1);
            if (s_q.cnt == CW'(NW - 1)) begin
                s_d.act = 1'b0;
                s_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fin  = s_q.fin;
    assign quot = s_q.q;
endmodule

// File: rtl/gid_lane_gen.sv
// Per-lane global index and active bit for one warp.
module gid_lane_gen #(
    parameter int LANES = 32,
    parameter int GW    = 17,
    parameter int TW    = 11
) (
    input  logic [GW-1:0]       wbase,
    input  logic [TW-1:0]       tid0,
    input  logic [GW-1:0]       lim_n,
    input  logic [TW-1:0]       lim_bd,
    output logic [LANES*GW-1:0] idx,
    output logic [LANES-1:0]    mask
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [GW-1:0] GOFF = GW'(l);
        localparam logic [TW-1:0] TOFF = TW'(l);
        logic [GW-1:0] gidx;
        logic [TW-1:0] tid;
        assign gidx              = wbase + GOFF;
        assign tid               = tid0 + TOFF;
        assign idx[l*GW +: GW]   = gidx;
        assign mask[l]           = (tid < lim_bd) && (gidx < lim_n);
    end
endmodule

// File: rtl/grid_warp_dispatcher.sv
module grid_warp_dispatcher
    import gid_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IDX_W = 16,
    parameter int BD_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [IDX_W-1:0]             cfg_n,
    input  logic [BD_W-1:0]              cfg_bdim,
    output logic                         busy,
    output logic                         done,
    output logic                         desc_valid,
    input  logic                         desc_ready,
    output logic [IDX_W-1:0]             desc_block,
    output logic [BD_W-1:0]              desc_warp,
    output logic [IDX_W:0]               desc_base,
    output logic [LANES-1:0]             desc_mask,
    output logic [LANES*(IDX_W+1)-1:0]   desc_idx
);
    localparam int GW = IDX_W + 1;   // global index width
    localparam int NW = IDX_W + 1;   // dividend / block count width
    localparam int TW = BD_W + 1;    // thread-in-block width
    localparam int WW = BD_W;        // warp number width

    typedef struct packed {
        gid_state_e     st;
        logic [IDX_W-1:0] n;
        logic [BD_W-1:0]  bd;
        logic [NW-1:0]    nblk;
        logic [NW-1:0]    blk;
        logic [WW-1:0]    warp;
        logic [TW-1:0]    tid0;
        logic [GW-1:0]    blkbase;
        logic             done;
    } walk_s;

    walk_s r_q, r_d;

    logic          div_go, div_fin;
    logic [NW-1:0] div_numer, div_quot;
    logic          cfg_zero;
    logic [TW-1:0] tid_nx;
    logic [NW-1:0] blk_nx;
    logic [GW-1:0] base_nx, wbase, wbase_nx;

    assign cfg_zero  = (cfg_n == '0) || (cfg_bdim == '0);
    assign div_go    = (r_q.st == ST_IDLE) && start && !cfg_zero;
    assign div_numer = NW'(cfg_n) + NW'(cfg_bdim) - NW'(1);

    gid_ceil_div #(.NW(NW), .DW(BD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (div_numer),
        .denom (r_q.bd),
        .fin   (div_fin),
        .quot  (div_quot)
    );

    assign wbase    = r_q.blkbase + GW'(r_q.tid0);
    assign tid_nx   = r_q.tid0 + TW'(LANES);
    assign wbase_nx = r_q.blkbase + GW'(tid_nx);
    assign blk_nx   = r_q.blk + NW'(1);
    assign base_nx  = r_q.blkbase + GW'(r_q.bd);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.n       = cfg_n;
                    r_d.bd      = cfg_bdim;
                    r_d.blk     = '0;
                    r_d.warp    = '0;
                    r_d.tid0    = '0;
                    r_d.blkbase = '0;
                    if (cfg_zero) r_d.done = 1'b1;
                    else          r_d.st   = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_fin) begin
                    r_d.nblk = div_quot;
                    r_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (desc_ready) begin
                    if (tid_nx < TW'(r_q.bd)) begin
                        // next warp in the same block
                        if (wbase_nx >= GW'(r_q.n)) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.warp = r_q.warp + WW'(1);
                            r_d.tid0 = tid_nx;
                        end
                    end else begin
                        // next block
                        if ((blk_nx == r_q.nblk) || (base_nx >= GW'(r_q.n))) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.blk     = blk_nx;
                            r_d.warp    = '0;
                            r_d.tid0    = '0;
                            r_d.blkbase = base_nx;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    gid_lane_gen #(.LANES(LANES), .GW(GW), .TW(TW)) u_lanes (
        .wbase  (wbase),
        .tid0   (r_q.tid0),
        .lim_n  (GW'(r_q.n)),
        .lim_bd (TW'(r_q.bd)),
        .idx    (desc_idx),
        .mask   (desc_mask)
    );

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign desc_valid = (r_q.st == ST_RUN);
    assign desc_block = r_q.blk[IDX_W-1:0];
    assign desc_warp  = r_q.warp;
    assign desc_base  = wbase;
endmodule

// File: rtl/gid_dispatch_chk.sv
module gid_dispatch_chk #(
    parameter int LANES = 32,
    parameter int IDX_W = 16,
    parameter int BD_W  = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       done,
    input logic                       desc_valid,
    input logic                       desc_ready,
    input logic [IDX_W-1:0]           desc_block,
    input logic [BD_W-1:0]            desc_warp,
    input logic [IDX_W:0]             desc_base,
    input logic [LANES-1:0]           desc_mask,
    input logic [LANES*(IDX_W+1)-1:0] desc_idx
);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_block)
            && $stable(desc_warp) && $stable(desc_base)
            && $stable(desc_mask) && $stable(desc_idx));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !desc_valid);

    assert_lane0_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_mask[0]);

    assert_lane0_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_idx[IDX_W:0] == desc_base);

    assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> busy);
endmodule

bind grid_warp_dispatcher gid_dispatch_chk #(
    .LANES(LANES), .IDX_W(IDX_W), .BD_W(BD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_block (desc_block),
    .desc_warp  (desc_warp),
    .desc_base  (desc_base),
    .desc_mask  (desc_mask),
    .desc_idx   (desc_idx)
);

// File: tb/tb_grid_warp_dispatcher.sv
`timescale 1ns/1ps
module tb_grid_warp_dispatcher;
    localparam int L  = 4;
    localparam int IW = 8;
    localparam int BW = 5;
    localparam int GW = IW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IW-1:0]     cfg_n = '0;
    logic [BW-1:0]     cfg_bdim = '0;
    logic              busy, done, desc_valid;
    logic              desc_ready = 1'b0;
    logic [IW-1:0]     desc_block;
    logic [BW-1:0]     desc_warp;
    logic [GW-1:0]     desc_base;
    logic [L-1:0]      desc_mask;
    logic [L*GW-1:0]   desc_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    grid_warp_dispatcher #(.LANES(L), .IDX_W(IW), .BD_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_n(cfg_n),
        .cfg_bdim(cfg_bdim), .busy(busy), .done(done),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_block(desc_block), .desc_warp(desc_warp),
        .desc_base(desc_base), .desc_mask(desc_mask), .desc_idx(desc_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_cfg(input int n, input int bd, input bit poke);
        int eb[$], ew[$], ebase[$], emask[$];
        int nblk, wpb, ptr, cyc, sb, sw, sbase, smask;
        bit fin, prev_stall, last_hs, hs;
        nblk = (bd == 0) ? 0 : (n + bd - 1) / bd;
        wpb  = (bd + L - 1) / L;
        for (int b = 0; b < nblk; b++) begin
            for (int w = 0; w < wpb; w++) begin
                int base, m;
                base = b * bd + w * L;
                if (base >= n) break;
                m = 0;
                for (int l = 0; l < L; l++)
                    if ((w * L + l < bd) && (base + l < n)) m |= (1 << l);
                eb.push_back(b); ew.push_back(w);
                ebase.push_back(base); emask.push_back(m);
            end
        end
        @(negedge clk);
        start = 1'b1; cfg_n = IW'(n); cfg_bdim = BW'(bd); desc_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (n == 0 || bd == 0) begin
            chk(done == 1'b1, "R8", "done after empty start", int'(done), 1);
            chk(desc_valid == 1'b0, "R8", "no descriptor", int'(desc_valid), 0);
            @(negedge clk);
            chk(done == 1'b0, "R7", "done single cycle", int'(done), 0);
            return;
        end
        chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        chk(done == 1'b0, "R10", "no early done", int'(done), 0);
        ptr = 0; cyc = 0; fin = 0; prev_stall = 0; last_hs = 0;
        sb = 0; sw = 0; sbase = 0; smask = 0;
        while (!fin && cyc < 3000) begin
            if (done) begin
                start = 1'b0;
                chk(ptr == eb.size(), "R5", "descriptor count", ptr, eb.size());
                chk(last_hs, "R7", "done follows last handshake", int'(last_hs), 1);
                chk(!busy && !desc_valid, "R7", "idle at done", int'(busy), 0);
                fin = 1;
            end else begin
                if (desc_valid) begin
                    chk(busy == 1'b1, "R10", "busy with valid", int'(busy), 1);
                    if (prev_stall) begin
                        chk(int'(desc_base) == sbase, "R6", "base held", int'(desc_base), sbase);
                        chk(int'(desc_mask) == smask, "R6", "mask held", int'(desc_mask), smask);
                        chk(int'(desc_block) == sb && int'(desc_warp) == sw, "R6",
                            "ids held", int'(desc_warp), sw);
                    end
                    if (ptr < eb.size()) begin
                        chk(int'(desc_block) == eb[ptr], "R4", "block order", int'(desc_block), eb[ptr]);
                        chk(int'(desc_warp) == ew[ptr], "R4", "warp order", int'(desc_warp), ew[ptr]);
                        chk(int'(desc_base) == ebase[ptr], "R2", "base index", int'(desc_base), ebase[ptr]);
                        chk(int'(desc_mask) == emask[ptr], "R3", "active mask", int'(desc_mask), emask[ptr]);
                        for (int l = 0; l < L; l++)
                            chk(int'(desc_idx[l*GW +: GW]) == ebase[ptr] + l, "R2", "lane index",
                                int'(desc_idx[l*GW +: GW]), ebase[ptr] + l);
                    end else begin
                        chk(1'b0, "R5", "extra descriptor", ptr, eb.size());
                    end
                end
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                desc_ready = lf[0] | lf[3];
                hs = desc_valid && desc_ready;
                prev_stall = desc_valid && !desc_ready;
                sb = int'(desc_block); sw = int'(desc_warp);
                sbase = int'(desc_base); smask = int'(desc_mask);
                last_hs = hs;
                if (hs) ptr++;
                // R9: stray start while busy must not disturb the walk
                if (poke && ptr == 1 && desc_valid) begin
                    start = 1'b1; cfg_n = IW'(n ^ 8'h55); cfg_bdim = BW'(7);
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!fin) chk(1'b0, "R7", "walk never finished", cyc, 3000);
        @(negedge clk);
        chk(done == 1'b0 && desc_valid == 1'b0, "R7", "done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        start = 1'b1; cfg_n = 8'd9; cfg_bdim = 5'd3;
        repeat (3) @(negedge clk);
        chk(!desc_valid, "R1", "valid in reset", int'(desc_valid), 0);
        chk(!busy, "R1", "busy in reset", int'(busy), 0);
        chk(!done, "R1", "done in reset", int'(done), 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!desc_valid && !busy && !done, "R1", "idle after reset", int'(busy), 0);
        for (int n = 0; n <= 40; n++)
            for (int bd = 0; bd <= 11; bd++)
                run_cfg(n, bd, ((n + bd) % 5) == 0);
        run_cfg(255, 31, 1'b1);
        run_cfg(255, 1, 1'b0);
        run_cfg(200, 24, 1'b1);
        run_cfg(32, 8, 1'b0);
        run_cfg(1, 31, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule